// File: doc/BRIEF.md
# Global History Branch Predictor

This block guesses the direction of conditional branches for a fetch stage. It keeps a table of two-bit saturating counters and a speculative history register holding the taken/not-taken outcomes of the most recent predicted branches. The history value is used directly as the table index, so no program-counter bits are involved. Two prediction requests can be served in the same cycle. The second one is indexed with the history already extended by the first one's guess, which lets a fetch group that holds two branches be predicted in one pass.

The prediction requests form a valid/ready stream. The block answers in the same cycle as the handshake, so `p0_taken`, `p0_ckpt`, `p1_taken` and `p1_ckpt` belong to the cycle in which `pred_ready` and the matching valid are both high. Each answer carries a checkpoint: the history value that was used as its index. The back end uses this checkpoint later in two ways. It trains the counter by sending the checkpoint back with the resolved outcome on an update port. On a wrong guess, it rolls the history back by driving the checkpoint and the correct outcome on the repair inputs. `pred_ready` is low in any cycle where a repair is applied, and a requester must then hold its request.

The history length `HIST_W` sets the table depth to 2^HIST_W. The full-size setting is 16, which gives 65536 counters. The default is 10 so that elaboration stays small.

Top module: `ghist_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 1 (weakly not taken), so every entry predicts not taken.
- R2: Counter codes are 0 strongly not taken, 1 weakly not taken, 2 weakly taken and 3 strongly taken. A prediction is taken exactly when the counter's upper bit is set (values 2 and 3).
- R3: Port 0 reads the counter at the index equal to the current speculative history. The newest outcome sits in bit 0 of the history.
- R4: When port 0 fires in a cycle, port 1 is indexed with {history[HIST_W-2:0], p0_taken}. When port 0 does not fire, port 1 uses the unshifted history.
- R5: Each prediction that fires shifts its predicted outcome into bit 0 of the history, so two shifts happen when both ports fire. With no prediction and no repair, the history holds its value.
- R6: An update with outcome taken raises the addressed counter by one, saturating at 3. An update with outcome not taken lowers it by one, saturating at 0.
- R7: When both update ports address the same entry in one cycle, port 0's step is applied first and port 1's step is then applied to that result.
- R8: A prediction that reads an entry in the same cycle as an update to that entry returns the value from before the update.
- R9: A repair loads the history with {fix_ckpt[HIST_W-2:0], fix_taken}. `pred_ready` is low during the repair cycle, and that cycle accepts no prediction.
- R10: `p0_ckpt` and `p1_ckpt` equal the index that each port used for its read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Prediction request, older branch |
| p1_valid | input | 1 | Prediction request, younger branch |
| pred_ready | output | 1 | Requests are accepted this cycle |
| p0_taken | output | 1 | Direction guess for port 0 |
| p0_ckpt | output | HIST_W | History used as port 0 index |
| p1_taken | output | 1 | Direction guess for port 1 |
| p1_ckpt | output | HIST_W | History used as port 1 index |
| u0_valid | input | 1 | Training update, port 0 |
| u0_hist | input | HIST_W | Checkpoint of the branch being trained |
| u0_taken | input | 1 | Resolved outcome |
| u1_valid | input | 1 | Training update, port 1 (applied after port 0) |
| u1_hist | input | HIST_W | Checkpoint of the branch being trained |
| u1_taken | input | 1 | Resolved outcome |
| fix_valid | input | 1 | History repair after a wrong guess |
| fix_ckpt | input | HIST_W | Checkpoint of the mispredicted branch |
| fix_taken | input | 1 | Correct outcome of that branch |

## Verification
The counter assertions assume the table is touched only through the update ports. For the single-update cases they also assume that port 1 is idle, so that a taken step from a value below 3 shows up as a plain increment. The history assertions assume that a repair is not combined with accepted predictions, which the block enforces through `pred_ready`. The stimulus points many updates at the live history value so that R8 same-cycle collisions happen often. It also forces both update ports onto one entry for a share of cycles, and uses repair to steer the history onto entries driven into saturation in both directions.

// File: rtl/ghp_pkg.sv
`timescale 1ns/1ps
package ghp_pkg;
  typedef logic [1:0] ctr_t;

  // weakly not taken
  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return res;
  endfunction
endpackage

// File: rtl/ghp_ctr_table.sv
`timescale 1ns/1ps
module ghp_ctr_table
  import ghp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int RD_N  = 2,
  parameter int WR_N  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [RD_N-1:0][IDX_W-1:0]  rd_idx,
  output logic [RD_N-1:0]             rd_taken,
  input  logic [WR_N-1:0]             wr_en,
  input  logic [WR_N-1:0][IDX_W-1:0]  wr_idx,
  input  logic [WR_N-1:0]             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t ctr_d [DEPTH];

  // reads see the registered array: old value on a same-cycle update
  for (genvar g = 0; g < RD_N; g++) begin : g_rd
    assign rd_taken[g] = ctr_q[rd_idx[g]][1];
  end

  // write ports applied in port order, so a shared entry takes both steps
  always_comb begin
    ctr_d = ctr_q;
    for (int p = 0; p < WR_N; p++) begin
      if (wr_en[p]) ctr_d[wr_idx[p]] = ctr_step(ctr_d[wr_idx[p]], wr_taken[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CTR_INIT;
    end else begin
      ctr_q <= ctr_d;
    end
  end

  // R6
  ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == WR_N'(1) && wr_taken[0] && ctr_q[wr_idx[0]] != CTR_MAX)
    |=> ctr_q[$past(wr_idx[0])] == $past(ctr_q[wr_idx[0]]) + 2'd1);

  // R6
  ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == WR_N'(1) && !wr_taken[0] && ctr_q[wr_idx[0]] == CTR_MIN)
    |=> ctr_q[$past(wr_idx[0])] == CTR_MIN);

  // R6
  ctr_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == WR_N'(1) && wr_taken[0] && ctr_q[wr_idx[0]] == CTR_MAX)
    |=> ctr_q[$past(wr_idx[0])] == CTR_MAX);
endmodule

// File: rtl/ghp_history.sv
`timescale 1ns/1ps
module ghp_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire0,
  input  logic              bit0,
  input  logic              fire1,
  input  logic              bit1,
  input  logic              restore,
  input  logic [HIST_W-1:0] restore_ckpt,
  input  logic              restore_bit,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] hist_mid
);
  logic [HIST_W-1:0] hist_d;

  // history seen by the younger port
  assign hist_mid = fire0 ? {hist_q[HIST_W-2:0], bit0} : hist_q;

  always_comb begin
    if (restore)    hist_d = {restore_ckpt[HIST_W-2:0], restore_bit};
    else if (fire1) hist_d = {hist_mid[HIST_W-2:0], bit1};
    else            hist_d = hist_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R9
  hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> hist_q == {$past(restore_ckpt[HIST_W-2:0]), $past(restore_bit)});

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !fire0 && !fire1) |=> $stable(hist_q));

  // R5
  hist_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && fire0 && !fire1) |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(bit0)});
endmodule

// File: rtl/ghist_predictor.sv
`timescale 1ns/1ps
module ghist_predictor #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_valid,
  input  logic              p1_valid,
  output logic              pred_ready,
  output logic              p0_taken,
  output logic [HIST_W-1:0] p0_ckpt,
  output logic              p1_taken,
  output logic [HIST_W-1:0] p1_ckpt,
  input  logic              u0_valid,
  input  logic [HIST_W-1:0] u0_hist,
  input  logic              u0_taken,
  input  logic              u1_valid,
  input  logic [HIST_W-1:0] u1_hist,
  input  logic              u1_taken,
  input  logic              fix_valid,
  input  logic [HIST_W-1:0] fix_ckpt,
  input  logic              fix_taken
);
  localparam int N_PORTS = 2;

  logic [HIST_W-1:0]               hist_q;
  logic [HIST_W-1:0]               hist_mid;
  logic [N_PORTS-1:0][HIST_W-1:0]  rd_idx;
  logic [N_PORTS-1:0]              rd_taken;
  logic                            fire0;
  logic                            fire1;

  assign pred_ready = !fix_valid;
  assign fire0      = p0_valid && pred_ready;
  assign fire1      = p1_valid && pred_ready;

  assign rd_idx   = {hist_mid, hist_q};
  assign p0_taken = rd_taken[0];
  assign p1_taken = rd_taken[1];
  assign p0_ckpt  = hist_q;
  assign p1_ckpt  = hist_mid;

  ghp_history #(.HIST_W(HIST_W)) u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire0        (fire0),
    .bit0         (p0_taken),
    .fire1        (fire1),
    .bit1         (p1_taken),
    .restore      (fix_valid),
    .restore_ckpt (fix_ckpt),
    .restore_bit  (fix_taken),
    .hist_q       (hist_q),
    .hist_mid     (hist_mid)
  );

  ghp_ctr_table #(.IDX_W(HIST_W), .RD_N(N_PORTS), .WR_N(N_PORTS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_taken (rd_taken),
    .wr_en    ({u1_valid, u0_valid}),
    .wr_idx   ({u1_hist, u0_hist}),
    .wr_taken ({u1_taken, u0_taken})
  );

  // R4
  chain_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && pred_ready) |-> p1_ckpt == {p0_ckpt[HIST_W-2:0], p0_taken});

  // R9
  fix_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid |-> !pred_ready);
endmodule

// File: tb/ghist_predictor_tb.sv
`timescale 1ns/1ps
module ghist_predictor_tb;
  localparam int HW   = 10;
  localparam int N    = 1 << HW;
  localparam int MASK = N - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          p0_valid, p1_valid, pred_ready;
  logic          p0_taken, p1_taken;
  logic [HW-1:0] p0_ckpt, p1_ckpt;
  logic          u0_valid, u0_taken, u1_valid, u1_taken;
  logic [HW-1:0] u0_hist, u1_hist;
  logic          fix_valid, fix_taken;
  logic [HW-1:0] fix_ckpt;

  ghist_predictor #(.HIST_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .p0_valid(p0_valid), .p1_valid(p1_valid), .pred_ready(pred_ready),
    .p0_taken(p0_taken), .p0_ckpt(p0_ckpt),
    .p1_taken(p1_taken), .p1_ckpt(p1_ckpt),
    .u0_valid(u0_valid), .u0_hist(u0_hist), .u0_taken(u0_taken),
    .u1_valid(u1_valid), .u1_hist(u1_hist), .u1_taken(u1_taken),
    .fix_valid(fix_valid), .fix_ckpt(fix_ckpt), .fix_taken(fix_taken)
  );

  int ctr_m [N];
  int hist_m;
  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int step_m(input int c, input bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // one clock: drive, compare against model before the edge, advance model
  task automatic cyc(input string tag, input bit v0, input bit v1,
                     input bit uv0, input int uh0, input bit ut0,
                     input bit uv1, input int uh1, input bit ut1,
                     input bit fv, input int fh, input bit ft);
    bit rdy, f0, f1, t0, t1;
    int i1, nh;
    @(negedge clk);
    p0_valid = v0; p1_valid = v1;
    u0_valid = uv0; u0_hist = HW'(uh0); u0_taken = ut0;
    u1_valid = uv1; u1_hist = HW'(uh1); u1_taken = ut1;
    fix_valid = fv; fix_ckpt = HW'(fh); fix_taken = ft;
    #1;
    rdy = !fv;
    chk({tag, " R9 pred_ready"}, int'(pred_ready), int'(rdy));
    t0 = ctr_m[hist_m] >= 2;
    chk({tag, " R10 R3 p0_ckpt"}, int'(p0_ckpt), hist_m);
    chk({tag, " R2 R8 p0_taken"}, int'(p0_taken), int'(t0));
    f0 = v0 && rdy;
    i1 = f0 ? (((hist_m << 1) | int'(t0)) & MASK) : hist_m;
    t1 = ctr_m[i1] >= 2;
    chk({tag, " R4 R5 p1_ckpt"}, int'(p1_ckpt), i1);
    chk({tag, " R2 R8 p1_taken"}, int'(p1_taken), int'(t1));
    f1 = v1 && rdy;
    if (fv)      nh = ((fh << 1) | int'(ft)) & MASK;
    else if (f1) nh = ((i1 << 1) | int'(t1)) & MASK;
    else         nh = i1;
    @(posedge clk);
    hist_m = nh;
    if (uv0) ctr_m[uh0] = step_m(ctr_m[uh0], ut0);
    if (uv1) ctr_m[uh1] = step_m(ctr_m[uh1], ut1);
  endtask

  // point the history at idx via a repair, then observe it one cycle later
  task automatic probe(input string tag, input int idx);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, idx >> 1, idx[0]);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic train(input int idx, input bit t, input int times);
    for (int k = 0; k < times; k++) cyc("train", 0, 0, 1, idx, t, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int e = 0; e < N; e++) ctr_m[e] = 1;
    hist_m = 0;
    rst_n = 1'b0;
    p0_valid = 0; p1_valid = 0; u0_valid = 0; u1_valid = 0; fix_valid = 0;
    u0_hist = '0; u1_hist = '0; fix_ckpt = '0; u0_taken = 0; u1_taken = 0; fix_taken = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    chk("R1 reset p0_ckpt", int'(p0_ckpt), 0);
    chk("R1 reset p0_taken", int'(p0_taken), 0);
    chk("R1 reset p1_ckpt", int'(p1_ckpt), 0);
    for (int k = 0; k < 6; k++) probe("R1 init entry", (k * 171) & MASK);

    // R6 saturation upward: 5 taken, then one not-taken must leave 2
    train(37, 1, 5);
    probe("R6 sat-high", 37);
    train(37, 0, 1);
    probe("R6 after-dec", 37);
    // R6 saturation downward: 4 not-taken then one taken leaves 1
    train(38, 0, 4);
    train(38, 1, 1);
    probe("R6 sat-low", 38);
    train(38, 1, 1);
    probe("R6 rise", 38);

    // R7 two updates to one entry: 1 -> 2 -> 3, then 3 -> 3 -> 2
    cyc("R7 both", 0, 0, 1, 90, 1, 1, 90, 1, 0, 0, 0);
    cyc("R7 mixed", 0, 0, 1, 90, 1, 1, 90, 0, 0, 0, 0);
    probe("R7 check", 90);

    // R8 update to the live index in the same cycle as the prediction
    probe("R8 setup", 200);
    cyc("R8 collide", 1, 0, 1, 200, 1, 0, 0, 0, 0, 0, 0);
    probe("R8 after", 200);

    // R4 R5 dual prediction with a taken entry at the chained index
    train(2 * 37 + 1 & MASK, 1, 2);
    probe("R4 setup", 37);
    cyc("R4 dual", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5 after", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 repair blocks a request in the same cycle
    cyc("R9 stall", 1, 1, 0, 0, 0, 0, 0, 0, 1, 300, 1);
    cyc("R9 after", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // mixed traffic compared cycle by cycle against the model
    for (int c = 0; c < 3000; c++) begin
      bit v0, v1, uv0, uv1, fv;
      int uh0, uh1;
      v0  = ($urandom % 4) != 0;
      v1  = ($urandom % 2) != 0;
      uv0 = ($urandom % 3) != 0;
      uv1 = ($urandom % 3) == 0;
      uh0 = (($urandom % 2) != 0) ? hist_m : int'($urandom % N);
      uh1 = (($urandom % 3) == 0) ? uh0 : int'($urandom % N);
      fv  = ($urandom % 10) == 0;
      cyc("mix", v0, v1, uv0, uh0, 1'($urandom), uv1, uh1, 1'($urandom),
          fv, int'($urandom % N), 1'($urandom));
    end
    summary();
  end
endmodule